// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block is the clock-register slice of a byte-addressed, battery-backed memory map. It keeps the time of day and the calendar in BCD. Those registers sit in the last eight bytes below the top of the map. A strobe input drives a prescaler, and the prescaler advances the clock once per second. Every write to a time register is range-checked before it is loaded. A load restarts the prescaler, so the new second runs a full period.

The block also decodes every other address for the storage array behind it, which is external. Accesses above the implemented size, and accesses to two lockable 16-byte windows while their lock is on, read as 0xFF and never reach the array. Each lock bit flips on a one-cycle toggle pulse. Reads are combinational from the address. Writes take effect at the clock edge where `wr_i` is high.

Register offsets from MEM_SIZE-8 are fixed by the decode:
- 0: seconds
- 1: minutes
- 2: hours
- 3: weekday and century
- 4: date
- 5: month
- 6: two-digit year
- 7: ordinary memory

Top module: `rtc_regfile`

## Requirements
- R1: The seconds register (offset 0) reads as {stop, seconds[6:0]} in BCD. A write always stores bit 7 as the stop bit. It loads bits 6:0 only when they form valid BCD from 00 to 59.
- R2: While the stop bit is 1, no time field changes. After a write clears it, counting continues from the value held, one second per prescaler period.
- R3: Minutes (offset 1, bits 6:0, 00-59), hours (offset 2, bits 5:0, 00-23), month (offset 5, bits 4:0, 01-12) and year (offset 6, full byte, 00-99) load only valid in-range BCD. Bits above each field are dropped. Any other write leaves the field unchanged.
- R4: A write to offset 3 stores bits 2:0 as the weekday and bit 6 as the century flag. A read returns {0, century, 000, weekday}.
- R5: February has 29 days when BASE_YEAR plus the binary value of the two-digit year is divisible by 4. Otherwise it has 28.
- R6: A second past 23:59:59 carries through minutes, hours, date and month. The year wraps from 99 to 00, and the weekday steps 0 to 6 and then wraps to 0.
- R7: While lock bit k is set, window k (0x20-0x2F for k=0, 0x30-0x3F for k=1) reads 0xFF and writes do not raise `mem_we_o`.
- R8: A one-cycle pulse on `lock_tgl_i[k]` inverts lock bit k. A second pulse restores access.
- R9: An address at or above MEM_SIZE reads 0xFF and never raises `mem_we_o`. Clock registers never raise `mem_we_o`.
- R10: Time advances one second per PRESCALE cycles with `tick_i` high. Cycles with `tick_i` low do not count, and any time-register write restarts the count.
- R11: After reset the clock reads 00:00:00, weekday 0, century 0, date 01, month 01, year 00, with both locks off.
- R12: The date (offset 4, bits 5:0) accepts only 01-31. It rolls to 01 after the last day of the current month: 30 for April, June, September and November, 31 for the other months, and February per R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler strobe, PRESCALE strobes per second |
| lock_tgl_i | input | NUM_WIN | Lock toggle pulses, one per window |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| mem_rdata_i | input | 8 | Read data from the external storage array |
| mem_we_o | output | 1 | Write enable to the storage array |
| rdata_o | output | 8 | Read data |

## Verification
The checker checks the following on every cycle:
- out-of-range and locked reads return 0xFF with the storage write enable held low;
- the seconds, hours and month fields stay inside their legal ranges;
- a stopped clock holds still;
- a bad minutes value leaves the field untouched;
- each toggle pulse flips its lock.

The calendar carries can only be shown by the bench's directed scenarios. These are a year-end carry, February in leap and common years, and a 30-day month, along with the prescaler restart on a load and the resume after a stop.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic       cent;
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DATE = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_MEM  = 3'd7
  } rtc_field_e;

  localparam rtc_time_t RTC_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00,
                                      hour: 6'h00, cent: 1'b0, wday: 3'd0,
                                      date: 6'h01, mon: 5'h01, year: 8'h00};

  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo,
                                  input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_days(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE  = 1024,
  parameter int BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ld_en_i,
  input  rtc_field_e ld_field_i,
  input  logic [7:0] ld_data_i,
  output rtc_time_t  tm_o
);

  localparam int         PW    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
  localparam logic [1:0] BY_LO = 2'(BASE_YEAR % 4);

  rtc_time_t     tm_q, tm_d;
  logic [PW-1:0] presc_q, presc_d;
  logic [6:0]    yr_bin;
  logic          leap;
  logic [7:0]    last_day;
  logic [7:0]    inc_sec, inc_min, inc_hr, inc_dt, inc_mo, inc_yr;

  always_comb begin
    tm_d     = tm_q;
    presc_d  = presc_q;
    yr_bin   = bcd2bin(tm_q.year);
    leap     = (2'(yr_bin[1:0] + BY_LO) == 2'd0);
    last_day = month_days(tm_q.mon, leap);
    inc_sec  = bcd_inc({1'b0, tm_q.sec});
    inc_min  = bcd_inc({1'b0, tm_q.min});
    inc_hr   = bcd_inc({2'b0, tm_q.hour});
    inc_dt   = bcd_inc({2'b0, tm_q.date});
    inc_mo   = bcd_inc({3'b0, tm_q.mon});
    inc_yr   = bcd_inc(tm_q.year);
    if (ld_en_i) begin
      presc_d = '0;
      case (ld_field_i)
        FLD_SEC: begin
          tm_d.stop = ld_data_i[7];
          if (bcd_ok({1'b0, ld_data_i[6:0]}, 8'h00, 8'h59)) tm_d.sec = ld_data_i[6:0];
        end
        FLD_MIN:  if (bcd_ok({1'b0, ld_data_i[6:0]}, 8'h00, 8'h59)) tm_d.min = ld_data_i[6:0];
        FLD_HOUR: if (bcd_ok({2'b0, ld_data_i[5:0]}, 8'h00, 8'h23)) tm_d.hour = ld_data_i[5:0];
        FLD_WDAY: begin
          tm_d.wday = ld_data_i[2:0];
          tm_d.cent = ld_data_i[6];
        end
        FLD_DATE: if (bcd_ok({2'b0, ld_data_i[5:0]}, 8'h01, 8'h31)) tm_d.date = ld_data_i[5:0];
        FLD_MON:  if (bcd_ok({3'b0, ld_data_i[4:0]}, 8'h01, 8'h12)) tm_d.mon = ld_data_i[4:0];
        FLD_YEAR: if (bcd_ok(ld_data_i, 8'h00, 8'h99)) tm_d.year = ld_data_i;
        default: ;
      endcase
    end else if (tick_i && !tm_q.stop) begin
      if (presc_q != P_LAST) begin
        presc_d = presc_q + 1'b1;
      end else begin
        presc_d = '0;
        if (tm_q.sec < 7'h59) tm_d.sec = inc_sec[6:0];
        else begin
          tm_d.sec = 7'h00;
          if (tm_q.min < 7'h59) tm_d.min = inc_min[6:0];
          else begin
            tm_d.min = 7'h00;
            if (tm_q.hour < 6'h23) tm_d.hour = inc_hr[5:0];
            else begin
              tm_d.hour = 6'h00;
              tm_d.wday = (tm_q.wday >= 3'd6) ? 3'd0 : tm_q.wday + 3'd1;
              if ({2'b0, tm_q.date} < last_day) tm_d.date = inc_dt[5:0];
              else begin
                tm_d.date = 6'h01;
                if (tm_q.mon < 5'h12) tm_d.mon = inc_mo[4:0];
                else begin
                  tm_d.mon  = 5'h01;
                  tm_d.year = (tm_q.year >= 8'h99) ? 8'h00 : inc_yr;
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q    <= RTC_RESET;
      presc_q <= '0;
    end else begin
      tm_q    <= tm_d;
      presc_q <= presc_d;
    end
  end

  assign tm_o = tm_q;

endmodule

// File: rtl/rtc_access_gate.sv
module rtc_access_gate
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MEM_SIZE = 8192,
  parameter int NUM_WIN  = 2,
  parameter int WIN_BASE = 32,
  parameter int WIN_SIZE = 16
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [NUM_WIN-1:0] lock_i,
  input  rtc_time_t          tm_i,
  input  logic [7:0]         mem_rdata_i,
  output logic               ld_en_o,
  output rtc_field_e         ld_field_o,
  output logic               mem_we_o,
  output logic [7:0]         rdata_o
);

  localparam logic [31:0] TOP_ADDR = 32'(MEM_SIZE);
  localparam logic [31:0] CLK_BASE = 32'(MEM_SIZE - 8);

  logic [31:0]        addr_w;
  logic               in_mem, in_clk, prot;
  logic [2:0]         offs;
  logic [NUM_WIN-1:0] hit;

  assign addr_w = 32'(addr_i);
  assign in_mem = addr_w < TOP_ADDR;
  assign offs   = 3'(addr_w - CLK_BASE);
  assign in_clk = in_mem && (addr_w >= CLK_BASE) && (offs != 3'd7);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [31:0] LO = 32'(WIN_BASE + w * WIN_SIZE);
    localparam logic [31:0] HI = 32'(WIN_BASE + (w + 1) * WIN_SIZE);
    assign hit[w] = lock_i[w] && (addr_w >= LO) && (addr_w < HI);
  end

  assign prot       = |hit;
  assign ld_en_o    = wr_i && in_clk;
  assign ld_field_o = rtc_field_e'(offs);
  assign mem_we_o   = wr_i && in_mem && !in_clk && !prot;

  always_comb begin
    if (!in_mem || prot) begin
      rdata_o = 8'hFF;
    end else if (in_clk) begin
      case (rtc_field_e'(offs))
        FLD_SEC:  rdata_o = {tm_i.stop, tm_i.sec};
        FLD_MIN:  rdata_o = {1'b0, tm_i.min};
        FLD_HOUR: rdata_o = {2'b0, tm_i.hour};
        FLD_WDAY: rdata_o = {1'b0, tm_i.cent, 3'b000, tm_i.wday};
        FLD_DATE: rdata_o = {2'b0, tm_i.date};
        FLD_MON:  rdata_o = {3'b0, tm_i.mon};
        FLD_YEAR: rdata_o = tm_i.year;
        default:  rdata_o = mem_rdata_i;
      endcase
    end else begin
      rdata_o = mem_rdata_i;
    end
  end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_SIZE  = 8192,
  parameter int PRESCALE  = 1024,
  parameter int BASE_YEAR = 2000,
  parameter int NUM_WIN   = 2,
  parameter int WIN_BASE  = 32,
  parameter int WIN_SIZE  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [NUM_WIN-1:0] lock_tgl_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  input  logic [7:0]         mem_rdata_i,
  output logic               mem_we_o,
  output logic [7:0]         rdata_o
);

  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic [NUM_WIN-1:0] lock_q, lock_d;
  rtc_time_t          tm_q;
  logic               ld_en;
  rtc_field_e         ld_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb lock_d = lock_q ^ lock_tgl_i;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) lock_q <= '0;
    else             lock_q <= lock_d;
  end

  rtc_time_core #(.PRESCALE(PRESCALE), .BASE_YEAR(BASE_YEAR)) u_core (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick_i    (tick_i),
    .ld_en_i   (ld_en),
    .ld_field_i(ld_field),
    .ld_data_i (wdata_i),
    .tm_o      (tm_q)
  );

  rtc_access_gate #(.ADDR_W(ADDR_W), .MEM_SIZE(MEM_SIZE), .NUM_WIN(NUM_WIN),
                    .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_gate (
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .lock_i     (lock_q),
    .tm_i       (tm_q),
    .mem_rdata_i(mem_rdata_i),
    .ld_en_o    (ld_en),
    .ld_field_o (ld_field),
    .mem_we_o   (mem_we_o),
    .rdata_o    (rdata_o)
  );

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MEM_SIZE = 8192,
  parameter int NUM_WIN  = 2,
  parameter int WIN_BASE = 32,
  parameter int WIN_SIZE = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_WIN-1:0] lock_tgl_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic [7:0]         wdata_i,
  input logic               mem_we_o,
  input logic [7:0]         rdata_o,
  input logic [NUM_WIN-1:0] lock_q,
  input rtc_time_t          tm_q
);

  localparam logic [31:0] MIN_ADDR = 32'(MEM_SIZE - 7);
  localparam logic [31:0] W0_LO    = 32'(WIN_BASE);
  localparam logic [31:0] W0_HI    = 32'(WIN_BASE + WIN_SIZE);

  logic out_rng, win0_locked;
  assign out_rng     = 32'(addr_i) >= 32'(MEM_SIZE);
  assign win0_locked = lock_q[0] && (32'(addr_i) >= W0_LO) && (32'(addr_i) < W0_HI);

  assert_oor_read_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_rng |-> (rdata_o == 8'hFF) && !mem_we_o);

  assert_locked_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win0_locked |-> (rdata_o == 8'hFF) && !mem_we_o);

  assert_sec_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q.sec <= 7'h59) && (tm_q.sec[3:0] <= 4'd9));

  assert_field_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q.hour <= 6'h23) && (tm_q.mon >= 5'h01) && (tm_q.mon <= 5'h12));

  assert_stop_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q.stop && !wr_i) |=> $stable(tm_q.sec) && $stable(tm_q.min) && $stable(tm_q.date));

  assert_bad_min_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (32'(addr_i) == MIN_ADDR) && ({1'b0, wdata_i[6:0]} > 8'h59)) |=> $stable(tm_q.min));

  assert_lock_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tgl_i[0] |=> (lock_q[0] != $past(lock_q[0])));

endmodule

bind rtc_regfile rtc_regfile_chk #(
  .ADDR_W(ADDR_W), .MEM_SIZE(MEM_SIZE), .NUM_WIN(NUM_WIN),
  .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_tgl_i(lock_tgl_i),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .mem_we_o  (mem_we_o),
  .rdata_o   (rdata_o),
  .lock_q    (lock_q),
  .tm_q      (tm_q)
);

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;

  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 4;
  localparam logic [15:0] A_SEC = 16'h1FF8, A_MIN = 16'h1FF9, A_HR = 16'h1FFA,
                          A_WD = 16'h1FFB, A_DT = 16'h1FFC, A_MO = 16'h1FFD,
                          A_YR = 16'h1FFE, A_M7 = 16'h1FFF;
  localparam logic [7:0] MEMV = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [1:0]  tgl;
  logic [15:0] addr;
  logic        wr;
  logic [7:0]  wdata;
  logic        mem_we;
  logic [7:0]  rdata;
  logic        last_we;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_regfile #(.ADDR_W(16), .MEM_SIZE(8192), .PRESCALE(PRE), .BASE_YEAR(1970)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lock_tgl_i(tgl), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .mem_rdata_i(MEMV), .mem_we_o(mem_we), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    addr = a; wr = 1'b0; #1; d = rdata;
  endtask

  task automatic rchk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wrb(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; #1; last_we = mem_we;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic secs(input int n);
    repeat (PRE * n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_lock(input logic [1:0] m);
    tgl = m; @(posedge clk); @(negedge clk); tgl = 2'b00;
  endtask

  task automatic set_time(input logic [7:0] y, mo, dt, wd, h, mi, s);
    wrb(A_YR, y); wrb(A_MO, mo); wrb(A_DT, dt); wrb(A_WD, wd);
    wrb(A_HR, h); wrb(A_MIN, mi); wrb(A_SEC, s);
  endtask

  task automatic t_reset;
    rchk("R11 sec", A_SEC, 8'h00); rchk("R11 min", A_MIN, 8'h00);
    rchk("R11 hour", A_HR, 8'h00); rchk("R11 wday", A_WD, 8'h00);
    rchk("R11 date", A_DT, 8'h01); rchk("R11 mon", A_MO, 8'h01);
    rchk("R11 year", A_YR, 8'h00); rchk("R11 lock0 open", 16'h0025, MEMV);
  endtask

  task automatic t_seconds;
    wrb(A_SEC, 8'h45); rchk("R1 load", A_SEC, 8'h45);
    wrb(A_SEC, 8'h60); rchk("R1 range", A_SEC, 8'h45);
    wrb(A_SEC, 8'h3A); rchk("R1 bad digit", A_SEC, 8'h45);
    chk("R9 clock reg no we", {7'b0, last_we}, 8'h00);
  endtask

  task automatic t_stop;
    tick = 1'b1;
    wrb(A_SEC, 8'hB0); rchk("R2 stop stored", A_SEC, 8'hB0);
    secs(5); rchk("R2 frozen", A_SEC, 8'hB0);
    wrb(A_SEC, 8'h30); rchk("R2 resume value", A_SEC, 8'h30);
    secs(1); rchk("R2 resume count", A_SEC, 8'h31);
  endtask

  task automatic t_ranges;
    wrb(A_MIN, 8'h59); rchk("R3 min ok", A_MIN, 8'h59);
    wrb(A_MIN, 8'h60); rchk("R3 min bad", A_MIN, 8'h59);
    wrb(A_HR, 8'h23);  rchk("R3 hour ok", A_HR, 8'h23);
    wrb(A_HR, 8'h24);  rchk("R3 hour bad", A_HR, 8'h23);
    wrb(A_HR, 8'hC5);  rchk("R3 hour mask", A_HR, 8'h05);
    wrb(A_MO, 8'h12);  rchk("R3 mon ok", A_MO, 8'h12);
    wrb(A_MO, 8'h13);  rchk("R3 mon 13", A_MO, 8'h12);
    wrb(A_MO, 8'h00);  rchk("R3 mon 0", A_MO, 8'h12);
    wrb(A_YR, 8'h99);  rchk("R3 year ok", A_YR, 8'h99);
    wrb(A_YR, 8'h9A);  rchk("R3 year bad", A_YR, 8'h99);
    wrb(A_DT, 8'h32);  rchk("R12 date 32", A_DT, 8'h01);
    wrb(A_DT, 8'h00);  rchk("R12 date 0", A_DT, 8'h01);
  endtask

  task automatic t_wday;
    wrb(A_WD, 8'h45); rchk("R4 cent+wday", A_WD, 8'h45);
    wrb(A_WD, 8'hBB); rchk("R4 mask", A_WD, 8'h03);
  endtask

  task automatic t_rollover;
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    secs(1);
    rchk("R6 sec", A_SEC, 8'h00); rchk("R6 min", A_MIN, 8'h00);
    rchk("R6 hour", A_HR, 8'h00); rchk("R6 wday", A_WD, 8'h00);
    rchk("R6 date", A_DT, 8'h01); rchk("R6 mon", A_MO, 8'h01);
    rchk("R6 year", A_YR, 8'h00);
  endtask

  task automatic t_calendar;
    set_time(8'h30, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    secs(1); rchk("R5 leap feb29", A_DT, 8'h29); rchk("R5 leap mon", A_MO, 8'h02);
    set_time(8'h30, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    secs(1); rchk("R5 after 29 date", A_DT, 8'h01); rchk("R5 after 29 mon", A_MO, 8'h03);
    set_time(8'h31, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    secs(1); rchk("R5 common date", A_DT, 8'h01); rchk("R5 common mon", A_MO, 8'h03);
    set_time(8'h31, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    secs(1); rchk("R12 apr date", A_DT, 8'h01); rchk("R12 apr mon", A_MO, 8'h05);
    set_time(8'h31, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    secs(1); rchk("R12 may 31", A_DT, 8'h31);
  endtask

  task automatic t_locks;
    wrb(16'h0025, 8'h11); chk("R7 open we", {7'b0, last_we}, 8'h01);
    pulse_lock(2'b01);
    rchk("R8 lock0 on", 16'h0025, 8'hFF);
    wrb(16'h0025, 8'h11); chk("R7 locked we", {7'b0, last_we}, 8'h00);
    rchk("R7 win1 open", 16'h0035, MEMV);
    rchk("R7 below window", 16'h001F, MEMV);
    pulse_lock(2'b10);
    rchk("R7 win1 locked", 16'h003F, 8'hFF);
    pulse_lock(2'b01);
    rchk("R8 lock0 off", 16'h0020, MEMV);
    pulse_lock(2'b10);
    rchk("R8 lock1 off", 16'h0030, MEMV);
  endtask

  task automatic t_range_edge;
    rchk("R9 oor read", 16'h2000, 8'hFF);
    wrb(16'h2000, 8'h00); chk("R9 oor we", {7'b0, last_we}, 8'h00);
    rchk("R9 top mem", A_M7, MEMV);
    wrb(A_M7, 8'h00); chk("R9 top mem we", {7'b0, last_we}, 8'h01);
  endtask

  task automatic t_prescaler;
    tick = 1'b0;
    wrb(A_SEC, 8'h10);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rchk("R10 no tick", A_SEC, 8'h10);
    tick = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wrb(A_SEC, 8'h20);
    repeat (PRE - 1) @(posedge clk);
    @(negedge clk);
    rchk("R10 restart hold", A_SEC, 8'h20);
    @(posedge clk); @(negedge clk);
    rchk("R10 restart step", A_SEC, 8'h21);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; tgl = 2'b00; addr = '0; wr = 1'b0; wdata = '0;
    last_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_seconds();
    t_stop();
    t_ranges();
    t_wday();
    t_rollover();
    t_calendar();
    t_locks();
    t_range_edge();
    t_prescaler();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule